// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a bus-attached timer. A 16-bit counter steps downward once per prescaler tick. The prescaler divides the input clock by 1, 16 or 256. Software writes a start value, picks a prescale and a counting mode, and sets the enable bit. From then on the count can be read back at any time, and it can be used to measure elapsed time.

Each time a tick brings the count to zero, the block raises a level interrupt. That interrupt stays high until software writes to the clear register. After reaching zero, the counter does one of two things on the next tick:

- in free-running mode it wraps to the all-ones value;
- in periodic mode it restarts from the stored start value.

With a start value of 0xFFFF, control 0x88 gives an enabled, free-running counter over the full range, divided by 256.

The bus is word addressed. Address bits [3:2] select a register and the low two bits are ignored. Writes take effect at the clock edge on which write enable is high. Read data is combinational from the address.

Top module: `ptmr_timer`

## Requirements
- R1: After reset, the start-value, count and control registers read as zero and the interrupt is low.
- R2: Register map and read format:
  - offset 0x0 is the start value;
  - offset 0x4 is the count, with bits 31:16 always reading zero;
  - offset 0x8 is control: bit 7 enable, bit 6 periodic, bits 3:2 prescale, all other bits reading zero;
  - offset 0xC reads as zero.
- R3: A write to 0x0 stores bits 15:0 as the start value and also places them in the counter at the same edge.
- R4: While control bit 7 is 0, the count holds its value and the prescaler is held cleared.
- R5: Prescale codes are 00 for divide by 1, 01 for divide by 16, 10 for divide by 256, and 11 for divide by 1. With divide N, the first decrement after a write to 0x0 or 0x8 occurs at the N-th rising edge after the write edge.
- R6: With control bit 6 at 0 (free-running), a tick at count 0 moves the count to 0xFFFF.
- R7: With control bit 6 at 1 (periodic), a tick at count 0 moves the count to the stored start value.
- R8: A tick whose next count is 0 sets the interrupt output, which then stays high until cleared.
- R9: Any write to offset 0xC clears the interrupt. If a set occurs at the same edge, the set wins.
- R10: A write to 0x0 or 0x8 restarts the prescaler from zero and suppresses the tick in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_we | input | 1 | Write enable, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The bench aims at the following corner cases, and at what a wrong design would do in each:

- **Prescale timing.** A prescaler that is off by one, or that keeps running across a rewrite of control, would decrement a cycle early or late. This is exposed at divide 256 and divide 16.
- **Zero crossing in each mode.** A design that mixes up wrap and reload would show 0xFFFF where the start value belongs, or the reverse.
- **Clear colliding with a new set.** If the clear wins, an interrupt is lost.
- **Reserved prescale code and upper read bits.** A design that decodes these wrongly would count too slowly or leak stale bits onto the bus.

Constrained random traffic then checks every read and the interrupt, cycle by cycle, against a model built from the requirements.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   typedef enum logic [1:0] {
      PS_DIV1    = 2'b00,
      PS_DIV_MID = 2'b01,
      PS_DIV_HI  = 2'b10,
      PS_RSVD    = 2'b11
   } ps_sel_e;

   typedef enum logic [1:0] {
      RG_START = 2'd0,
      RG_COUNT = 2'd1,
      RG_CTRL  = 2'd2,
      RG_ICLR  = 2'd3
   } reg_idx_e;

   typedef struct packed {
      logic    en;
      logic    periodic;
      ps_sel_e ps;
   } ctrl_t;

   localparam int CTRL_EN_BIT  = 7;
   localparam int CTRL_PER_BIT = 6;
   localparam int CTRL_PS_LSB  = 2;
   localparam int CTRL_BYTE_W  = 8;

endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  start_q,
   output ctrl_t             ctrl_q,
   output logic              start_wr,
   output logic              ctrl_wr,
   output logic              clr_wr,
   output logic [DATA_W-1:0] rdata
);

   localparam int IDX_LSB = 2;

   reg_idx_e                idx;
   logic [CTRL_BYTE_W-1:0]  ctrl_byte;
   logic                    unused_bits;

   assign idx      = reg_idx_e'(addr[IDX_LSB+1:IDX_LSB]);
   assign start_wr = we && (idx == RG_START);
   assign ctrl_wr  = we && (idx == RG_CTRL);
   assign clr_wr   = we && (idx == RG_ICLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         ctrl_q  <= '0;
      end else begin
         if (start_wr) start_q <= wdata[CNT_W-1:0];
         if (ctrl_wr) begin
            ctrl_q.en       <= wdata[CTRL_EN_BIT];
            ctrl_q.periodic <= wdata[CTRL_PER_BIT];
            ctrl_q.ps       <= ps_sel_e'(wdata[CTRL_PS_LSB+1:CTRL_PS_LSB]);
         end
      end
   end

   always_comb begin
      ctrl_byte = '0;
      ctrl_byte[CTRL_EN_BIT]                   = ctrl_q.en;
      ctrl_byte[CTRL_PER_BIT]                  = ctrl_q.periodic;
      ctrl_byte[CTRL_PS_LSB+1:CTRL_PS_LSB]     = ctrl_q.ps;
   end

   always_comb begin
      case (idx)
         RG_START: rdata = DATA_W'(start_q);
         RG_COUNT: rdata = DATA_W'(count);
         RG_CTRL:  rdata = DATA_W'(ctrl_byte);
         default:  rdata = '0;
      endcase
   end

   generate
      if (ADDR_W > IDX_LSB + 2) begin : g_hi_addr
         assign unused_bits = ^{addr[1:0], addr[ADDR_W-1:IDX_LSB+2], wdata[DATA_W-1:CNT_W]};
      end else begin : g_no_hi_addr
         assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CNT_W]};
      end
   endgenerate

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
   import ptmr_pkg::*;
#(
   parameter int MID_LOG2 = 4,
   parameter int HI_LOG2  = 8
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en,
   input  ps_sel_e ps,
   input  logic    restart,
   output logic    tick
);

   localparam int PW = HI_LOG2;

   logic [PW-1:0] pre_q;
   logic [PW-1:0] lim;

   always_comb begin
      case (ps)
         PS_DIV_MID: lim = {{(PW-MID_LOG2){1'b0}}, {MID_LOG2{1'b1}}};
         PS_DIV_HI:  lim = '1;
         default:    lim = '0;
      endcase
   end

   assign tick = en && !restart && (pre_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pre_q <= '0;
      else if (!en || restart || tick) pre_q <= '0;
      else                             pre_q <= pre_q + 1'b1;
   end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_wr,
   input  logic [CNT_W-1:0] start_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             periodic,
   input  logic             tick,
   input  logic             clr_wr,
   output logic [CNT_W-1:0] count,
   output logic             irq
);

   logic [CNT_W-1:0] next_val;
   logic             hit_zero;

   always_comb begin
      if (count == '0) next_val = periodic ? reload_val : '1;
      else             next_val = count - 1'b1;
   end

   assign hit_zero = tick && (next_val == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         irq   <= 1'b0;
      end else begin
         if (start_wr)  count <= start_val;
         else if (tick) count <= next_val;

         if (hit_zero)    irq <= 1'b1;
         else if (clr_wr) irq <= 1'b0;
      end
   end

endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer
   import ptmr_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter int MID_LOG2 = 4,
   parameter int HI_LOG2  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ptmr_timer: ADDR_W must be at least 4");
      end
      if (DATA_W <= CNT_W || DATA_W < CTRL_BYTE_W) begin : g_bad_data
         $error("ptmr_timer: DATA_W must exceed CNT_W and hold the control byte");
      end
      if (MID_LOG2 < 1 || HI_LOG2 <= MID_LOG2) begin : g_bad_div
         $error("ptmr_timer: need 1 <= MID_LOG2 < HI_LOG2");
      end
   endgenerate

   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] count_w;
   ctrl_t            ctrl_q;
   logic             start_wr;
   logic             ctrl_wr;
   logic             clr_wr;
   logic             tick_w;

   ptmr_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .count    (count_w),
      .start_q  (start_q),
      .ctrl_q   (ctrl_q),
      .start_wr (start_wr),
      .ctrl_wr  (ctrl_wr),
      .clr_wr   (clr_wr),
      .rdata    (bus_rdata)
   );

   ptmr_prescaler #(
      .MID_LOG2 (MID_LOG2),
      .HI_LOG2  (HI_LOG2)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctrl_q.en),
      .ps      (ctrl_q.ps),
      .restart (start_wr | ctrl_wr),
      .tick    (tick_w)
   );

   ptmr_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_wr   (start_wr),
      .start_val  (bus_wdata[CNT_W-1:0]),
      .reload_val (start_q),
      .periodic   (ctrl_q.periodic),
      .tick       (tick_w),
      .clr_wr     (clr_wr),
      .count      (count_w),
      .irq        (irq)
   );

endmodule

// File: rtl/ptmr_timer_chk.sv
module ptmr_timer_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic              start_wr,
   input logic              ctrl_wr,
   input logic              clr_wr,
   input logic              tick,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  start_q,
   input logic              en,
   input logic              periodic,
   input logic [1:0]        ps
);

   AST_COUNT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[3:2] == 2'b01) |-> (bus_rdata[DATA_W-1:CNT_W] == '0)); // R2

   AST_START_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (count == $past(bus_wdata[CNT_W-1:0]))); // R3

   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !start_wr) |=> $stable(count)); // R4

   AST_DIV1_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !start_wr && !ctrl_wr && (ps == 2'b00 || ps == 2'b11)) |-> tick); // R5

   AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '0 && !periodic) |=> (count == '1)); // R6

   AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '0 && periodic) |=> (count == $past(start_q))); // R7

   AST_IRQ_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == CNT_W'(1)) |=> irq); // R8

   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_wr) |=> irq); // R8

   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !tick) |=> !irq); // R9

   AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr || ctrl_wr) |-> !tick); // R10

endmodule

bind ptmr_timer ptmr_timer_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .start_wr  (start_wr),
   .ctrl_wr   (ctrl_wr),
   .clr_wr    (clr_wr),
   .tick      (tick_w),
   .count     (count_w),
   .start_q   (start_q),
   .en        (ctrl_q.en),
   .periodic  (ctrl_q.periodic),
   .ps        (ctrl_q.ps)
);

// File: tb/ptmr_timer_tb.sv
module ptmr_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  bus_addr;
   logic        bus_we;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int bad    = 0;

   always #10 clk = ~clk;

   ptmr_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // reference model, written from the requirements
   logic [15:0] m_start, m_cnt;
   logic        m_en, m_per, m_irq;
   logic [1:0]  m_ps;
   logic [7:0]  m_pre;

   function automatic logic [7:0] div_lim(input logic [1:0] ps);
      case (ps)
         2'b01:   return 8'd15;
         2'b10:   return 8'd255;
         default: return 8'd0;
      endcase
   endfunction

   function automatic logic [31:0] model_rd(input logic [3:0] a);
      case (a[3:2])
         2'd0:    return {16'h0, m_start};
         2'd1:    return {16'h0, m_cnt};
         2'd2:    return {24'h0, m_en, m_per, 2'b00, m_ps, 2'b00};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_start <= '0; m_cnt <= '0; m_en <= 0; m_per <= 0;
         m_ps <= '0; m_pre <= '0; m_irq <= 0;
      end else begin
         logic ldw, cw, clw, tk;
         logic [15:0] nxt;
         ldw = bus_we && bus_addr[3:2] == 2'd0;
         cw  = bus_we && bus_addr[3:2] == 2'd2;
         clw = bus_we && bus_addr[3:2] == 2'd3;
         tk  = m_en && !ldw && !cw && (m_pre == div_lim(m_ps));
         nxt = (m_cnt == 0) ? (m_per ? m_start : 16'hFFFF) : m_cnt - 16'd1;
         m_pre <= (!m_en || ldw || cw || tk) ? 8'd0 : m_pre + 8'd1;
         if (ldw) begin m_cnt <= bus_wdata[15:0]; m_start <= bus_wdata[15:0]; end
         else if (tk) m_cnt <= nxt;
         if (cw) begin m_en <= bus_wdata[7]; m_per <= bus_wdata[6]; m_ps <= bus_wdata[3:2]; end
         if (tk && nxt == 0) m_irq <= 1'b1;
         else if (clw)       m_irq <= 1'b0;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", checks, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd_chk(4'h0, 32'h0, "R1 start");
      rd_chk(4'h4, 32'h0, "R1 count");
      rd_chk(4'h8, 32'h0, "R1 ctrl");
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R3 / R2: start write loads count; upper count bits zero
      wr(4'h0, 32'hFFFF_ABCD);
      rd_chk(4'h4, 32'h0000_ABCD, "R2 R3 count upper zero");
      rd_chk(4'hC, 32'h0, "R2 clear reg reads zero");
      wr(4'h0, 32'h0000_FFFF);
      rd_chk(4'h0, 32'h0000_FFFF, "R3 start");
      rd_chk(4'h4, 32'h0000_FFFF, "R3 count");
      wr(4'h8, 32'hFFFF_FF88);
      rd_chk(4'h8, 32'h0000_0088, "R2 ctrl format");
      // R5 divide by 256: first decrement at edge 256 after the write
      repeat (255) @(negedge clk);
      rd_chk(4'h4, 32'h0000_FFFF, "R5 div256 before");
      @(negedge clk);
      rd_chk(4'h4, 32'h0000_FFFE, "R5 div256 at 256");

      // R6 / R8 free-running wrap with interrupt
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h2);
      wr(4'h8, 32'h80);
      @(negedge clk);
      rd_chk(4'h4, 32'h1, "R5 div1 step");
      check("R8 irq low before zero", {31'b0, irq}, 32'h0);
      @(negedge clk);
      rd_chk(4'h4, 32'h0, "R8 count zero");
      check("R8 irq set", {31'b0, irq}, 32'h1);
      @(negedge clk);
      rd_chk(4'h4, 32'hFFFF, "R6 wrap");
      check("R8 irq held", {31'b0, irq}, 32'h1);
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h0);
      check("R9 clear", {31'b0, irq}, 32'h0);
      repeat (5) @(negedge clk);
      rd_chk(4'h4, 32'hFFFF, "R4 disabled holds");

      // R7 periodic reload; R9 set wins over clear
      wr(4'h0, 32'h1);
      wr(4'h8, 32'hC0);
      @(negedge clk);
      rd_chk(4'h4, 32'h0, "R7 first zero");
      check("R8 irq periodic", {31'b0, irq}, 32'h1);
      @(negedge clk);
      rd_chk(4'h4, 32'h1, "R7 reload");
      @(negedge clk);
      @(negedge clk);
      wr(4'hC, 32'h0);
      rd_chk(4'h4, 32'h0, "R9 count at collide");
      check("R9 set wins", {31'b0, irq}, 32'h1);
      wr(4'hC, 32'h0);
      check("R9 clear after collide", {31'b0, irq}, 32'h0);

      // R5 reserved code as divide by 1
      wr(4'h8, 32'h0);
      wr(4'h0, 32'd10);
      wr(4'h8, 32'h8C);
      repeat (3) @(negedge clk);
      rd_chk(4'h4, 32'd7, "R5 reserved div1");

      // R10 control rewrite restarts divide-by-16 prescaler
      wr(4'h0, 32'd100);
      wr(4'h8, 32'h84);
      repeat (10) @(negedge clk);
      wr(4'h8, 32'h84);
      repeat (15) @(negedge clk);
      rd_chk(4'h4, 32'd100, "R10 restart holds");
      @(negedge clk);
      rd_chk(4'h4, 32'd99, "R10 first step at 16");

      // constrained random against the model (R2..R10)
      for (int i = 0; i < 4000; i++) begin
         int r;
         check("R2 random read", bus_rdata, model_rd(bus_addr));
         check("R8 R9 random irq", {31'b0, irq}, {31'b0, m_irq});
         r = $urandom_range(0, 99);
         if (r < 6) begin
            logic [1:0] ps;
            int p;
            p = $urandom_range(0, 9);
            ps = (p < 4) ? 2'b00 : (p < 8) ? 2'b01 : (p < 9) ? 2'b11 : 2'b10;
            bus_addr = 4'h8; bus_we = 1'b1;
            bus_wdata = {$urandom_range(0, 32'hFFFF), 8'h0, ($urandom_range(0, 9) < 8) ? 1'b1 : 1'b0,
                         1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), ps, 2'($urandom_range(0, 3))};
         end else if (r < 11) begin
            bus_addr = 4'h0; bus_we = 1'b1;
            bus_wdata = {$urandom_range(0, 32'hFFFF), 16'($urandom_range(0, 30))};
         end else if (r < 15) begin
            bus_addr = 4'hC; bus_we = 1'b1; bus_wdata = $urandom;
         end else begin
            bus_we = 1'b0;
            bus_addr = 4'($urandom_range(0, 3) << 2);
         end
         @(negedge clk);
      end

      summary();
      $finish;
   end

endmodule